// File: doc/BRIEF.md
# Exception Stacking Sequencer

This block saves processor state to memory when an exception or interrupt is taken. Once a request with its vector number is accepted, it stores the status word and then the return address on a stack that grows downward. It then reads the handler address from a vector table and hands that word back as the new program counter, together with the updated stack pointer. Every memory access is a single beat on a simple master port, and the sequencer waits for each one to be accepted.

The block also checks alignment. A stack pointer or vector base that is not a whole number of words is an address error. The current stacking still runs to the end: writes go to the word-aligned address and their data is flagged as meaningless. One address-error exception is then queued and starts by itself when the current sequence ends. Any alignment fault seen while stacking for that address-error exception is dropped, so control always reaches its handler and never loops.

Top module: `exc_stack_seq`

## Requirements
- R1: During and straight after reset, `req_ready` is 1 and `bus_valid`, `done` and `sp_out` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From then until its sequence (and any queued follow-on) is over, `req_ready` is 0, and `req_valid` or `req_vec` changes have no effect on the bus accesses.
- R3: A sequence makes two writes (`bus_write`=1). The first writes the status word to SP-4 and the second writes the return address to SP-8. After `done`, `sp_out` equals the entry SP minus 8 for each completed sequence.
- R4: Bus addresses always have their two low bits at 0. When the stack pointer's two low bits are not 00, the writes still happen at the aligned address, with `bus_wdef`=0 and `bus_wdata`=0. Otherwise `bus_wdef`=1 on writes.
- R5: After both writes, one read (`bus_write`=0) goes to VBR + 4 x vector number, with the two low bits cleared.
- R6: The word returned by that read appears on `pc_out`. `done` is a one-cycle pulse in the cycle after the read is accepted.
- R7: If the SP or the VBR is misaligned, the current sequence is not aborted. Exactly one follow-on sequence starts after its `done`, with vector number AE_VEC (default 9). It stacks the same status word and, as return address, the new PC, starting at the SP left by the first sequence.
- R8: Alignment faults seen during the follow-on sequence are ignored, so no third sequence starts: there are exactly two `done` pulses.
- R9: While `bus_valid` is 1 and `bus_ready` is 0, `bus_valid`, `bus_write` and `bus_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request |
| req_vec | input | VEC_W | Vector number of the request |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| sp_in | input | XLEN | Current stack pointer |
| sr_in | input | XLEN | Current status word |
| pc_in | input | XLEN | Return address |
| vbr_in | input | XLEN | Vector table base |
| bus_valid | output | 1 | Bus access pending |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | XLEN | Word-aligned access address |
| bus_wdata | output | XLEN | Write data |
| bus_wdef | output | 1 | Write data meaningful |
| bus_ready | input | 1 | Access accepted this cycle |
| bus_rdata | input | XLEN | Read data, taken when the read is accepted |
| sp_out | output | XLEN | Updated stack pointer |
| pc_out | output | XLEN | Handler address fetched last |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Some properties hold on every cycle, and the bound checker covers these: aligned bus addresses, stable access signals during wait states, no request acceptance while an access is pending, and a single-cycle done pulse right after each accepted read. Other properties depend on whole sequences and can only be shown by the bench's scenarios. These include the exact stacking addresses and data, the final stack pointer and program counter, exactly one queued address-error sequence after a misaligned stack pointer or base, and the dropping of a second fault while that sequence runs.

// File: rtl/exc_stack_pkg.sv
package exc_stack_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PUSH_SR = 2'd1,
      ST_PUSH_PC = 2'd2,
      ST_VEC_RD  = 2'd3
   } stk_state_e;
endpackage

// File: rtl/exc_align_chk.sv
// Splits an address into its word-aligned form and a misalignment flag.
module exc_align_chk #(
   parameter int XLEN = 32,
   parameter int LSB  = 2
) (
   input  logic [XLEN-1:0] addr_i,
   output logic            misal_o,
   output logic [XLEN-1:0] aligned_o
);
   generate
      if (LSB == 0) begin : g_byte
         assign misal_o   = 1'b0;
         assign aligned_o = addr_i;
      end else begin : g_word
         assign misal_o   = |addr_i[LSB-1:0];
         assign aligned_o = {addr_i[XLEN-1:LSB], {LSB{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/exc_vec_addr.sv
// Vector table entry address: base plus scaled vector number, then aligned.
module exc_vec_addr #(
   parameter int XLEN  = 32,
   parameter int VEC_W = 8,
   parameter int LSB   = 2
) (
   input  logic [XLEN-1:0]  vbr_i,
   input  logic [VEC_W-1:0] vec_i,
   output logic [XLEN-1:0]  addr_o,
   output logic             base_misal_o
);
   logic [XLEN-1:0] offset;
   logic [XLEN-1:0] sum;
   logic            sum_misal;

   assign offset = XLEN'(vec_i) << LSB;
   assign sum    = vbr_i + offset;

   exc_align_chk #(.XLEN(XLEN), .LSB(LSB)) u_align (
      .addr_i    (sum),
      .misal_o   (sum_misal),
      .aligned_o (addr_o)
   );

   // The scaled offset has zero low bits, so any misalignment comes from the base.
   assign base_misal_o = sum_misal;
endmodule

// File: rtl/exc_stack_seq.sv
module exc_stack_seq #(
   parameter int XLEN       = 32,
   parameter int VEC_W      = 8,
   parameter int WORD_BYTES = 4,
   parameter int AE_VEC     = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VEC_W-1:0] req_vec,
   output logic             req_ready,
   input  logic [XLEN-1:0]  sp_in,
   input  logic [XLEN-1:0]  sr_in,
   input  logic [XLEN-1:0]  pc_in,
   input  logic [XLEN-1:0]  vbr_in,
   output logic             bus_valid,
   output logic             bus_write,
   output logic [XLEN-1:0]  bus_addr,
   output logic [XLEN-1:0]  bus_wdata,
   output logic             bus_wdef,
   input  logic             bus_ready,
   input  logic [XLEN-1:0]  bus_rdata,
   output logic [XLEN-1:0]  sp_out,
   output logic [XLEN-1:0]  pc_out,
   output logic             done
);
   import exc_stack_pkg::*;

   localparam int LSB = $clog2(WORD_BYTES);
   localparam logic [XLEN-1:0]  STEP    = XLEN'(WORD_BYTES);
   localparam logic [VEC_W-1:0] AE_CODE = VEC_W'(AE_VEC);

   generate
      if (XLEN < 16) begin : g_bad_xlen
         $error("exc_stack_seq: XLEN must be at least 16");
      end
      if ((1 << LSB) != WORD_BYTES) begin : g_bad_word
         $error("exc_stack_seq: WORD_BYTES must be a power of two");
      end
      if (AE_VEC < 0 || AE_VEC >= (1 << VEC_W)) begin : g_bad_vec
         $error("exc_stack_seq: AE_VEC does not fit in VEC_W bits");
      end
   endgenerate

   stk_state_e      state_q;
   logic [XLEN-1:0] sp_work_q, sr_q, pc_q, vbr_q, vaddr_q, new_pc_q;
   logic            is_ae_q, ae_pend_q, vbr_bad_q, done_q;

   // Launch selection: a queued address error outranks a fresh request.
   logic             idle, start_ae, start_req, start_any;
   logic [XLEN-1:0]  sp_src, sr_src, pc_src, vbr_src;
   logic [VEC_W-1:0] vec_src;
   logic [XLEN-1:0]  vaddr_src;
   logic             vbr_src_bad;

   assign idle      = (state_q == ST_IDLE);
   assign start_ae  = idle && ae_pend_q;
   assign start_req = idle && !ae_pend_q && req_valid;
   assign start_any = start_ae || start_req;
   assign req_ready = idle && !ae_pend_q;

   assign sp_src  = start_ae ? sp_work_q : sp_in;
   assign sr_src  = start_ae ? sr_q      : sr_in;
   assign pc_src  = start_ae ? new_pc_q  : pc_in;
   assign vbr_src = start_ae ? vbr_q     : vbr_in;
   assign vec_src = start_ae ? AE_CODE   : req_vec;

   exc_vec_addr #(.XLEN(XLEN), .VEC_W(VEC_W), .LSB(LSB)) u_vec_addr (
      .vbr_i        (vbr_src),
      .vec_i        (vec_src),
      .addr_o       (vaddr_src),
      .base_misal_o (vbr_src_bad)
   );

   // Stack address path: the working SP keeps its low bits across decrements.
   logic            sp_bad;
   logic [XLEN-1:0] stk_addr;

   exc_align_chk #(.XLEN(XLEN), .LSB(LSB)) u_stk_align (
      .addr_i    (sp_work_q),
      .misal_o   (sp_bad),
      .aligned_o (stk_addr)
   );

   logic acc_fire, fault_now;
   assign acc_fire  = bus_valid && bus_ready;
   assign fault_now = (sp_bad || vbr_bad_q) && !is_ae_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         sp_work_q <= '0;
         sr_q      <= '0;
         pc_q      <= '0;
         vbr_q     <= '0;
         vaddr_q   <= '0;
         new_pc_q  <= '0;
         is_ae_q   <= 1'b0;
         ae_pend_q <= 1'b0;
         vbr_bad_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_any) begin
                  sp_work_q <= sp_src - STEP;
                  sr_q      <= sr_src;
                  pc_q      <= pc_src;
                  vbr_q     <= vbr_src;
                  vaddr_q   <= vaddr_src;
                  vbr_bad_q <= vbr_src_bad;
                  is_ae_q   <= start_ae;
                  state_q   <= ST_PUSH_SR;
                  if (start_ae) ae_pend_q <= 1'b0;
               end
            end
            ST_PUSH_SR: begin
               if (acc_fire) begin
                  if (fault_now) ae_pend_q <= 1'b1;
                  sp_work_q <= sp_work_q - STEP;
                  state_q   <= ST_PUSH_PC;
               end
            end
            ST_PUSH_PC: begin
               if (acc_fire) state_q <= ST_VEC_RD;
            end
            ST_VEC_RD: begin
               if (acc_fire) begin
                  new_pc_q <= bus_rdata;
                  done_q   <= 1'b1;
                  state_q  <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   logic [XLEN-1:0] wsel;
   assign wsel      = (state_q == ST_PUSH_SR) ? sr_q : pc_q;
   assign bus_valid = !idle;
   assign bus_write = (state_q == ST_PUSH_SR) || (state_q == ST_PUSH_PC);
   assign bus_addr  = bus_write ? stk_addr : vaddr_q;
   assign bus_wdef  = bus_write && !sp_bad;
   assign bus_wdata = bus_wdef ? wsel : '0;
   assign sp_out    = sp_work_q;
   assign pc_out    = new_pc_q;
   assign done      = done_q;
endmodule

// File: rtl/exc_stack_seq_chk.sv
module exc_stack_seq_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            bus_valid,
   input logic            bus_write,
   input logic [XLEN-1:0] bus_addr,
   input logic            bus_ready,
   input logic            done
);
   AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_addr[1:0] == 2'b00)); // R4

   AST_HOLD_DURING_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write))); // R9

   AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> !req_ready); // R2

   AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_ready) |=> done); // R6

   AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

   AST_DONE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_valid); // R6
endmodule

bind exc_stack_seq exc_stack_seq_chk #(.XLEN(XLEN)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_ready (bus_ready),
   .done      (done)
);

// File: tb/test_exc_stack_seq.sv
`timescale 1ns/1ps
module test_exc_stack_seq;
   localparam int AE = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_vec = '0;
   logic        req_ready;
   logic [31:0] sp_in = '0, sr_in = '0, pc_in = '0, vbr_in = '0;
   logic        bus_valid, bus_write, bus_wdef;
   logic [31:0] bus_addr, bus_wdata, bus_rdata;
   logic        bus_ready = 1'b0;
   logic [31:0] sp_out, pc_out;
   logic        done;

   always #10 clk = ~clk;

   function automatic logic [31:0] rd_of(input logic [31:0] a);
      return 32'hC000_0000 ^ a;
   endfunction
   function automatic logic [31:0] al(input logic [31:0] a);
      return {a[31:2], 2'b00};
   endfunction

   assign bus_rdata = rd_of(bus_addr);

   exc_stack_seq #(.AE_VEC(AE)) i_exc_stack_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
      .req_ready(req_ready), .sp_in(sp_in), .sr_in(sr_in), .pc_in(pc_in),
      .vbr_in(vbr_in), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wdef(bus_wdef),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata), .sp_out(sp_out),
      .pc_out(pc_out), .done(done)
   );

   int checks = 0;
   int fails  = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Bus responder and logger, all on the falling edge.
   int          cur_wait = 0;
   int          wcnt = 0;
   int          log_total = 0;
   int          done_cnt = 0;
   logic [31:0] log_addr [8];
   logic        log_wr   [8];
   logic [31:0] log_data [8];
   logic        log_def  [8];
   logic        prev_wait = 1'b0;
   logic [31:0] prev_addr = '0;
   logic        prev_wr = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ready = 1'b0;
         wcnt = 0;
         prev_wait = 1'b0;
      end else begin
         if (prev_wait) begin
            check(bus_valid && bus_addr == prev_addr && bus_write == prev_wr,
                  "R9", "access held in wait state", bus_addr, prev_addr);
         end
         if (bus_valid) begin
            if (wcnt >= cur_wait) begin bus_ready = 1'b1; wcnt = 0; end
            else begin bus_ready = 1'b0; wcnt++; end
         end else begin
            bus_ready = 1'b0;
            wcnt = 0;
         end
         prev_wait = bus_valid && !bus_ready;
         prev_addr = bus_addr;
         prev_wr   = bus_write;
         if (bus_valid && bus_ready) begin
            if (log_total < 8) begin
               log_addr[log_total] = bus_addr;
               log_wr[log_total]   = bus_write;
               log_data[log_total] = bus_wdata;
               log_def[log_total]  = bus_wdef;
            end
            log_total++;
         end
         if (done) done_cnt++;
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R6 watchdog: actual %h expected %h", 32'd0, 32'd1);
      summary();
      $finish;
   end

   // Runs one exception and compares the bus log with an independent model.
   task automatic run_case(input logic [31:0] sp, input logic [31:0] vbr,
                           input logic [7:0] vec, input int wt,
                           input logic [31:0] sr, input logic [31:0] pc,
                           input bit hold);
      logic [31:0] ea [6];
      logic        ew [6];
      logic [31:0] ed [6];
      logic        edf [6];
      int          en = 0;
      int          edone = 1;
      logic [31:0] np, fsp;
      bit          defd;
      int          guard;

      defd  = (sp[1:0] == 2'b00);
      ea[0] = al(sp - 4); ew[0] = 1; ed[0] = sr; edf[0] = defd;
      ea[1] = al(sp - 8); ew[1] = 1; ed[1] = pc; edf[1] = defd;
      ea[2] = al(vbr + {22'd0, vec, 2'b00}); ew[2] = 0; ed[2] = '0; edf[2] = 0;
      en  = 3;
      np  = rd_of(ea[2]);
      fsp = sp - 8;
      if (sp[1:0] != 2'b00 || vbr[1:0] != 2'b00) begin
         ea[3] = al(fsp - 4); ew[3] = 1; ed[3] = sr; edf[3] = defd;
         ea[4] = al(fsp - 8); ew[4] = 1; ed[4] = np; edf[4] = defd;
         ea[5] = al(vbr + AE * 4); ew[5] = 0; ed[5] = '0; edf[5] = 0;
         en    = 6;
         np    = rd_of(ea[5]);
         fsp   = fsp - 8;
         edone = 2;
      end

      @(negedge clk);
      cur_wait  = wt;
      log_total = 0;
      done_cnt  = 0;
      sp_in = sp; vbr_in = vbr; sr_in = sr; pc_in = pc; req_vec = vec;
      req_valid = 1'b1;
      @(negedge clk);
      check(!req_ready, "R2", "ready low after accept", {31'd0, req_ready}, 32'd0);
      if (hold) begin
         req_vec = 8'h55; sp_in = 32'h0000_7770; vbr_in = 32'h0000_0100;
         @(negedge clk);
         @(negedge clk);
      end
      req_valid = 1'b0;
      guard = 0;
      while (!(done_cnt >= 1 && req_ready) && guard < 500) begin
         @(negedge clk);
         guard++;
      end
      repeat (6) @(negedge clk);

      check(log_total == en, (edone == 2) ? "R8" : "R7", "access count",
            32'(log_total), 32'(en));
      for (int k = 0; k < en && k < log_total; k++) begin
         check(log_addr[k] == ea[k], ew[k] ? ((k >= 3) ? "R7" : "R3") : "R5",
               "address", log_addr[k], ea[k]);
         check(log_wr[k] == ew[k], "R3", "direction", {31'd0, log_wr[k]}, {31'd0, ew[k]});
         check(log_def[k] == edf[k], "R4", "data-defined flag",
               {31'd0, log_def[k]}, {31'd0, edf[k]});
         if (ew[k] && !edf[k])
            check(log_data[k] == '0, "R4", "undefined data zero", log_data[k], 32'd0);
         if (ew[k] && edf[k])
            check(log_data[k] == ed[k], (k >= 3) ? "R7" : "R3", "stacked data",
                  log_data[k], ed[k]);
      end
      check(done_cnt == edone, (edone == 2) ? "R8" : "R6", "done pulses",
            32'(done_cnt), 32'(edone));
      check(sp_out == fsp, "R3", "final stack pointer", sp_out, fsp);
      check(pc_out == np, "R6", "fetched handler address", pc_out, np);
   endtask

   // sp, vbr, vec, wait
   localparam logic [73:0] CASES [6] = '{
      {32'h0000_1000, 32'h0000_0400, 8'h20, 2'd0},
      {32'h0000_2002, 32'h0000_0400, 8'h11, 2'd1},
      {32'h0000_3000, 32'h0000_0502, 8'h05, 2'd2},
      {32'h0000_4001, 32'h0000_0603, 8'hFF, 2'd0},
      {32'h0000_0008, 32'h0000_0000, 8'h00, 2'd3},
      {32'h0000_5003, 32'h0000_0800, 8'h09, 2'd0}
   };

   initial begin
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1, "R1", "ready in reset", {31'd0, req_ready}, 32'd1);
      check(bus_valid == 1'b0, "R1", "bus idle in reset", {31'd0, bus_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1", "ready after reset", {31'd0, req_ready}, 32'd1);
      check(bus_valid == 1'b0, "R1", "bus idle after reset", {31'd0, bus_valid}, 32'd0);
      check(done == 1'b0, "R1", "done low after reset", {31'd0, done}, 32'd0);
      check(sp_out == '0, "R1", "sp_out after reset", sp_out, 32'd0);

      for (int i = 0; i < 6; i++) begin
         run_case(CASES[i][73:42], CASES[i][41:10], CASES[i][9:2], int'(CASES[i][1:0]),
                  32'h0000_00F0 + 32'(i), 32'h0800_0000 + 32'(i * 16), 1'b0);
      end

      // R2: request inputs changed while busy must not alter the sequence.
      run_case(32'h0000_6000, 32'h0000_0200, 8'h03, 2, 32'h0000_00AA,
               32'h0900_0000, 1'b1);
      // R7/R8 with wait states on a misaligned stack pointer.
      run_case(32'h0000_6102, 32'h0000_0A03, 8'h40, 1, 32'h0000_00BB,
               32'h0900_0100, 1'b1);

      summary();
      $finish;
   end
endmodule